// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus (I2C). Through it a host reads and writes a 256-entry byte register space that lives outside the block. A strap input picks one of two 7-bit device addresses. After a matching address byte with the write direction, the host sends a subaddress byte and then any number of data bytes. Each data byte is offered to the storage, and the subaddress pointer then moves on to the next entry. To read, the host first writes the subaddress, issues a repeated START, and then addresses the block for reading. The block then shifts out bytes, most significant bit first, until the host answers a byte with NACK.

Every access is screened against a fixed region map. Read-write entries take writes. Read-only entries still acknowledge writes, but no store is issued. Reserved entries acknowledge writes, are never stored, and read back as zero. Both bus lines are oversampled in the system clock domain through a two-stage synchroniser. All bus decisions are made on the synchronised edges, so the core logic has a single clock.

Top module: `bus_reg_slave`

## Requirements
- R1: With `strap_alt` low the block acknowledges address byte 0x4A (write) and 0x4B (read). With `strap_alt` high it acknowledges 0x48 and 0x49 instead. Bit 0 of the address byte is the direction: 0 means write and 1 means read.
- R2: An address byte that does not match the strap-selected address is not acknowledged. Every later byte is then ignored, with no acknowledge and no store, until the next START.
- R3: In a write transaction the subaddress byte and every data byte are acknowledged. Each data byte sent to a read-write entry produces a one-cycle `reg_we` pulse with `reg_addr` equal to the current pointer and `reg_wdata` equal to the byte.
- R4: After each data byte, written or read, the pointer advances by one. It wraps from 0xFF to 0x00.
- R5: In a combined read (subaddress write, repeated START, read address), the block returns the entry at the pointer, most significant bit first, and returns the next entry for each byte the host acknowledges.
- R6: Region map. 0x00, 0x1F and 0x60–0x62 are read-only. 0x01–0x13, 0x15–0x17 and 0x40–0x5F are read-write. All other entries are reserved. Writes to read-only or reserved entries are acknowledged, but `reg_we` stays low.
- R7: Reading a reserved entry returns 0x00, whatever the storage presents on `reg_rdata`.
- R8: When the host answers a read byte with NACK, the block releases SDA. It drives nothing more until the next START or STOP, after which a new transaction works normally.
- R9: A START or STOP seen at any bit position, including in the middle of a byte, aborts the current byte without a store. A START begins a fresh address phase, and SDA is released on either condition.
- R10: SDA is released after reset. The block starts pulling SDA low only while the synchronised SCL is low. Timing is driven by synchronised edges, so fast-mode bus rates (400 kbit/s) need only a system clock well above the SCL rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level as sampled at the pad |
| sda_i | input | 1 | SDA line level as sampled at the pad |
| sda_o | output | 1 | SDA output value, always 0 (open-drain) |
| sda_oe | output | 1 | SDA pull-low enable; 1 drives the line low |
| strap_alt | input | 1 | Address strap: 0 selects 0x4A/0x4B, 1 selects 0x48/0x49 |
| reg_addr | output | 8 | Register pointer, used as both the read and the write address |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_we | output | 1 | One-cycle store strobe for read-write entries |
| reg_rdata | input | 8 | Storage contents at `reg_addr` (combinational) |

## Verification
The main function is exercised in two ways. First, a single 256-byte write burst starting at 0x10 covers every entry. Second, a single 256-byte read burst starting at 0x80 covers every entry again. Each burst passes through the 0xFF-to-0x00 wrap, and the data pattern is computed arithmetically from the address, so a wrong pointer step or wrap shows up as a misplaced value. Because the map is swept entry by entry, a region boundary that is off by one shows up either as a stored value where the preset should survive or as a non-zero read from a reserved entry. Short directed transactions cover the cases that the bursts cannot tell apart: both strap settings against both address pairs, aborts mid-byte by STOP and by repeated START, and the host NACK that ends a read.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    localparam int BYTE_W  = 8;
    localparam int BCNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BCNT_W-1:0] bcnt_t;

    typedef enum logic [1:0] {
        REG_RSVD = 2'd0,
        REG_RO   = 2'd1,
        REG_RW   = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_WR,
        PH_RD,
        PH_WAIT
    } phase_e;

    // Synchronised bus levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic  we;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    function automatic region_e region_of(byte_t a);
        if (a == 8'h00 || a == 8'h1F || (a >= 8'h60 && a <= 8'h62))
            return REG_RO;
        if ((a >= 8'h01 && a <= 8'h13) || (a >= 8'h15 && a <= 8'h17) ||
            (a >= 8'h40 && a <= 8'h5F))
            return REG_RW;
        return REG_RSVD;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import regslv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= scl_i;
                    sda_p <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= {scl_p[STAGES-2:0], scl_i};
                    sda_p <= {sda_p[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
    end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import regslv_pkg::*;
#(
    parameter logic [6:0] ADDR_DEF = 7'h25,
    parameter logic [6:0] ADDR_ALT = 7'h24
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    strap_alt,
    input  byte_t   rd_byte,
    output logic    sda_oe,
    output byte_t   ptr,
    output wr_req_t wr
);

    localparam bcnt_t FULL = bcnt_t'(BYTE_W);

    phase_e     phase;
    bcnt_t      cnt;
    logic       in_ack;
    logic       rw;
    byte_t      shreg;
    byte_t      txb;
    logic [6:0] own_addr;

    assign own_addr = strap_alt ? ADDR_ALT : ADDR_DEF;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            in_ack <= 1'b0;
            rw     <= 1'b0;
            shreg  <= '0;
            txb    <= '0;
            ptr    <= '0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.we <= 1'b0;
            if (ev.start) begin
                phase  <= PH_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_ADDR, PH_SUB, PH_WR: begin
                        if (ev.rise && !in_ack && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && !in_ack && cnt == FULL) begin
                            cnt <= '0;
                            if (phase == PH_ADDR) begin
                                if (shreg[BYTE_W-1:1] == own_addr) begin
                                    sda_oe <= 1'b1;
                                    in_ack <= 1'b1;
                                    rw     <= shreg[0];
                                end else begin
                                    phase <= PH_WAIT;
                                end
                            end else if (phase == PH_SUB) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                in_ack <= 1'b1;
                            end else begin
                                wr.we   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= shreg;
                                sda_oe  <= 1'b1;
                                in_ack  <= 1'b1;
                            end
                        end else if (ev.fall && in_ack) begin
                            in_ack <= 1'b0;
                            sda_oe <= 1'b0;
                            if (phase == PH_ADDR) begin
                                if (rw) begin
                                    phase  <= PH_RD;
                                    txb    <= rd_byte;
                                    sda_oe <= ~rd_byte[BYTE_W-1];
                                    cnt    <= bcnt_t'(1);
                                end else begin
                                    phase <= PH_SUB;
                                end
                            end else if (phase == PH_SUB) begin
                                phase <= PH_WR;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                        end
                    end
                    PH_RD: begin
                        if (ev.fall && !in_ack) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                in_ack <= 1'b1;
                            end else begin
                                sda_oe <= ~txb[BYTE_W-2];
                                txb    <= {txb[BYTE_W-2:0], 1'b0};
                                cnt    <= cnt + 1'b1;
                            end
                        end else if (ev.rise && in_ack) begin
                            ptr <= ptr + 1'b1;
                            if (ev.sda) begin
                                phase <= PH_WAIT;
                            end
                        end else if (ev.fall && in_ack) begin
                            in_ack <= 1'b0;
                            txb    <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            cnt    <= bcnt_t'(1);
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/reg_region_gate.sv
module reg_region_gate
    import regslv_pkg::*;
(
    input  wr_req_t wr,
    input  byte_t   rd_addr,
    input  byte_t   raw_rdata,
    output logic    store_en,
    output byte_t   rd_byte
);

    always_comb begin
        store_en = wr.we && (region_of(wr.addr) == REG_RW);
        rd_byte  = (region_of(rd_addr) == REG_RSVD) ? '0 : raw_rdata;
    end

endmodule

// File: rtl/bus_reg_slave.sv
module bus_reg_slave
    import regslv_pkg::*;
#(
    parameter logic [6:0] ADDR_DEF    = 7'h25,
    parameter logic [6:0] ADDR_ALT    = 7'h24,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe,
    input  logic       strap_alt,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);

    bus_ev_t ev;
    wr_req_t wr;
    byte_t   ptr;
    byte_t   rd_byte;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_byte_engine #(
        .ADDR_DEF (ADDR_DEF),
        .ADDR_ALT (ADDR_ALT)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap_alt (strap_alt),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .ptr       (ptr),
        .wr        (wr)
    );

    reg_region_gate u_gate (
        .wr        (wr),
        .rd_addr   (ptr),
        .raw_rdata (reg_rdata),
        .store_en  (reg_we),
        .rd_byte   (rd_byte)
    );

    assign sda_o     = 1'b0;
    assign reg_addr  = ptr;
    assign reg_wdata = wr.data;

endmodule

// File: rtl/bus_reg_slave_chk.sv
module bus_reg_slave_chk
    import regslv_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input bus_ev_t    ev,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_addr
);

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);                                                 // R3

    AST_WE_RW_ONLY: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> ((reg_addr >= 8'h01 && reg_addr <= 8'h13) ||
                    (reg_addr >= 8'h15 && reg_addr <= 8'h17) ||
                    (reg_addr >= 8'h40 && reg_addr <= 8'h5F)));              // R6

    AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);                                          // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);                                                // R9

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe);                                               // R9

endmodule

bind bus_reg_slave bus_reg_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr)
);

// File: tb/bus_reg_slave_test.sv
module bus_reg_slave_test;

    localparam int H = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_o, sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_line;
    logic [7:0] mem [256];
    int         we_count = 0;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    bus_reg_slave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_o     (sda_o),
        .sda_oe    (sda_oe),
        .strap_alt (strap),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] preset(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // 0 reserved, 1 read-only, 2 read-write
    function automatic int kind(input int a);
        if (a == 0 || a == 31 || (a >= 96 && a <= 98)) return 1;
        if ((a >= 1 && a <= 19) || (a >= 21 && a <= 23) || (a >= 64 && a <= 95)) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 256; a++) mem[a] <= preset(a);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_count++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        b = sda_line; tick(H - H / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic write1(input logic [7:0] dev, input logic [7:0] sub,
                          input logic [7:0] d, input string tag);
        logic a;
        bus_start();
        put_byte(dev, a); check({tag, " addr ack"}, a, 1);
        put_byte(sub, a); check({tag, " sub ack"}, a, 1);
        put_byte(d, a);   check({tag, " data ack"}, a, 1);
        bus_stop();
    endtask

    task automatic read1(input logic [7:0] sub, input logic [7:0] exp, input string tag);
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(8'h4A, a); check({tag, " addr W ack"}, a, 1);
        put_byte(sub, a);   check({tag, " sub ack"}, a, 1);
        bus_start();
        put_byte(8'h4B, a); check({tag, " addr R ack"}, a, 1);
        get_byte(v, 1'b0);  check({tag, " data"}, v, exp);
        bus_stop();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic a;
        logic b;
        logic [7:0] v;
        int wc;

        tick(6);
        rst = 1'b0;
        tick(4);
        // R10: reset state releases SDA, no store strobe
        check("R10 reset sda_oe", sda_oe, 0);
        check("R10 reset reg_we", reg_we, 0);
        check("R10 sda_o constant", sda_o, 0);

        // R1/R3: default address write, then readback (R5)
        write1(8'h4A, 8'h05, 8'h3C, "R1 R3 default write");
        check("R3 stored value", mem[5], 8'h3C);
        check("R3 store count", we_count, 1);
        read1(8'h05, 8'h3C, "R1 R5 default read");

        // R2: strap-alt address while strap low is refused
        wc = we_count;
        bus_start();
        put_byte(8'h48, a); check("R2 wrong addr nack", a, 0);
        put_byte(8'h06, a); check("R2 later byte nack", a, 0);
        put_byte(8'h11, a); check("R2 later data nack", a, 0);
        bus_stop();
        check("R2 no store", we_count, wc);

        // R1: strap high selects 0x48/0x49, refuses 0x4A
        strap = 1'b1;
        tick(4);
        write1(8'h48, 8'h06, 8'h5A, "R1 strap write");
        check("R1 strap stored", mem[6], 8'h5A);
        bus_start();
        put_byte(8'h4A, a); check("R2 default addr refused under strap", a, 0);
        bus_stop();
        bus_start();
        put_byte(8'h48, a); check("R1 strap W", a, 1);
        put_byte(8'h06, a); check("R1 strap sub", a, 1);
        bus_start();
        put_byte(8'h49, a); check("R1 strap R", a, 1);
        get_byte(v, 1'b0);  check("R1 strap readback", v, 8'h5A);
        bus_stop();
        strap = 1'b0;
        tick(4);

        // R6: read-only and reserved writes acked but not stored
        wc = we_count;
        write1(8'h4A, 8'h00, 8'hFF, "R6 ro write");
        write1(8'h4A, 8'h14, 8'h77, "R6 rsvd write");
        write1(8'h4A, 8'h61, 8'h12, "R6 ro high write");
        check("R6 no strobe", we_count, wc);
        read1(8'h00, preset(0), "R6 ro unchanged");
        read1(8'h61, preset(8'h61), "R6 ro high unchanged");
        read1(8'h14, 8'h00, "R7 rsvd read zero");

        // R9: STOP mid-byte aborts, no store
        wc = we_count;
        bus_start();
        put_byte(8'h4A, a); check("R9 addr", a, 1);
        put_byte(8'h05, a); check("R9 sub", a, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        check("R9 stop abort no store", we_count, wc);
        check("R9 stop sda released", sda_oe, 0);
        // R9: repeated START mid-byte restarts the address phase
        bus_start();
        put_byte(8'h4A, a); check("R9 addr2", a, 1);
        put_byte(8'h05, a); check("R9 sub2", a, 1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        put_byte(8'h4A, a); check("R9 restart addr ack", a, 1);
        put_byte(8'h05, a); check("R9 restart sub ack", a, 1);
        put_byte(8'h99, a); check("R9 restart data ack", a, 1);
        bus_stop();
        check("R9 restart stored", mem[5], 8'h99);
        check("R9 one store", we_count, wc + 1);

        // R8: host NACK ends the read, SDA stays released
        bus_start();
        put_byte(8'h4A, a); check("R8 addr", a, 1);
        put_byte(8'h40, a); check("R8 sub", a, 1);
        bus_start();
        put_byte(8'h4B, a); check("R8 addr R", a, 1);
        get_byte(v, 1'b1);  check("R8 first byte", v, preset(8'h40));
        get_byte(v, 1'b0);  check("R8 second byte", v, preset(8'h41));
        tick(4);
        check("R8 released after nack", sda_oe, 0);
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            check("R8 silent after nack", b, 1);
        end
        bus_stop();
        read1(8'h41, preset(8'h41), "R8 next transaction");

        // R3/R4/R6: 256-byte write burst from 0x10, wrapping through 0xFF
        wc = we_count;
        bus_start();
        put_byte(8'h4A, a); check("R3 burst addr", a, 1);
        put_byte(8'h10, a); check("R3 burst sub", a, 1);
        for (int i = 0; i < 256; i++) begin
            int ad;
            ad = (16 + i) & 255;
            put_byte(pattern(ad), a);
            if (a != 1) check("R3 burst data ack", a, 1);
        end
        bus_stop();
        check("R6 burst store count", we_count - wc, 54);
        for (int ad = 0; ad < 256; ad++) begin
            check($sformatf("R4 R6 map entry %0h", ad), mem[ad],
                  (kind(ad) == 2) ? pattern(ad) : preset(ad));
        end

        // R4/R5/R7: 256-byte read burst from 0x80, wrapping through 0xFF
        bus_start();
        put_byte(8'h4A, a); check("R5 burst addr W", a, 1);
        put_byte(8'h80, a); check("R5 burst sub", a, 1);
        bus_start();
        put_byte(8'h4B, a); check("R5 burst addr R", a, 1);
        for (int i = 0; i < 256; i++) begin
            int ad;
            int ex;
            ad = (128 + i) & 255;
            ex = (kind(ad) == 2) ? pattern(ad) : (kind(ad) == 1) ? preset(ad) : 0;
            get_byte(v, (i != 255));
            check($sformatf("R5 R7 read entry %0h", ad), v, ex);
        end
        bus_stop();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule